// File: doc/BRIEF.md
# Bus-Master Write DMA Progress Engine

This block runs one bus-master write transfer. Data moves from local image memory out to a host bus. A descriptor-load strobe hands the engine a destination byte address and a byte count, the way a scatter-gather entry would supply them. The engine checks both values. If they are acceptable, it presents one DWORD write beat at a time on a valid/ready port. It keeps a live destination pointer, which always names the next unwritten location, and a live remaining-byte count. Both values can be read back through a small register read port.

A register read taken while a transfer is running pauses the write port for that cycle, so that the access can be served in target mode. The value returned is the one held at the moment of the read. The engine then continues from the held pointer and count, with no beat lost and none repeated. When the count reaches zero the engine goes idle. If the interrupt enable is set, it raises a sticky end-of-transfer flag, which software clears by writing one.

Top module: `bmw_dma_engine`

## Requirements
- R1: In idle, a load with a DWORD-aligned address and a nonzero count that is a multiple of 4 makes the engine busy from the next cycle. While the engine is busy and no read is pending, `wr_valid` is high.
- R2: The two low bits of `wr_addr` are zero on every cycle in which `wr_valid` is high. This marks linear, burst-capable ordering.
- R3: On every cycle in which `wr_valid` and `wr_ready` are both high, the pointer rises by 4 and the count falls by 4. On any other cycle neither value changes.
- R4: The beat that brings the count to zero is the last one. From the next cycle `busy` and `wr_valid` are low, and the pointer holds one DWORD past the last address written.
- R5: The interrupt flag is set on the cycle after the last beat, but only if `irq_en` was high on that beat. It stays set until `irq_clear` is asserted. If a set and a clear arrive in the same cycle, the set wins.
- R6: A read (`reg_rd` high) forces `wr_valid` low in that cycle. On the next cycle `reg_rdata` holds the value from before that edge. `reg_sel`=0 selects the 32-bit pointer. `reg_sel`=1 selects the count in bits 21:0, with bits 31:22 reading as zero. `reg_rdata` holds its value between reads.
- R7: Across any mix of pauses and stalls, the addresses of completed beats form one contiguous ascending DWORD sequence, starting at the loaded address and covering exactly count/4 beats.
- R8: An idle load with an address whose bits 1:0 are not zero, a count whose bits 1:0 are not zero, or a zero count is rejected. `err` is set, the engine stays idle, and no beat is issued. An accepted load clears `err`.
- R9: A load presented while the engine is busy is ignored. Pointer, count and flags are unchanged.
- R10: After reset the engine is idle, `wr_valid`, `irq`, `err` are low, and the pointer, the count and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_load | input | 1 | Descriptor load strobe |
| desc_addr | input | 32 | Destination byte address |
| desc_count | input | 22 | Byte count |
| irq_en | input | 1 | End-of-transfer interrupt enable |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt flag |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the pointer, 1 selects the count |
| reg_rdata | output | 32 | Captured read data |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted by the host side |
| wr_addr | output | 32 | Destination of the offered beat |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky end-of-transfer flag |
| err | output | 1 | Last idle load was rejected |

## Verification
The assertions check the following on every cycle:
- the zero low address bits whenever a beat is offered;
- the 4-byte pointer step on each handshake and the hold without one;
- the silencing of the write port during a read;
- the stickiness of the interrupt flag;
- the rejection of misaligned descriptors.

Some behaviour only the bench scenarios can show. These are the contiguity of the beat sequence across mixed stalls and pauses, the exact beat count at which the transfer ends, and the read-back values with the count's upper bits at zero. They also cover the gating of the interrupt by its enable and the discarding of loads while busy. The bench compares all of these against a behavioural model on every clock.

// File: rtl/bmw_pkg.sv
// Shared constants and types for the bus-master write engine.
// Assumes byte addressing with a fixed DWORD beat.
package bmw_pkg;
    localparam int BEAT_BYTES = 4;
    localparam int ALIGN_BITS = 2;

    typedef enum logic {
        SEL_POINTER = 1'b0,
        SEL_COUNT   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/bmw_desc_check.sv
// Descriptor validation: flags a descriptor as usable when the address
// and the count are both DWORD aligned and the count is nonzero.
// Purely combinational; assumes the caller qualifies it with the load strobe.
module bmw_desc_check #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic              ok
);
    import bmw_pkg::*;

    // Alignment and nonzero test
    always_comb begin
        ok = (addr[ALIGN_BITS-1:0] == '0) &&
             (count[ALIGN_BITS-1:0] == '0) &&
             (count != '0);
    end
endmodule

// File: rtl/bmw_progress.sv
// Transfer progress registers: the live pointer, the remaining byte count
// and the busy state. Assumes start arrives only when idle, and that beat
// is already qualified by busy. last marks the beat that empties the count.
module bmw_progress #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              beat,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              last
);
    import bmw_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BEAT_BYTES);

    // Last-beat detection
    always_comb begin
        last = beat && (count == CNT_STEP);
    end

    // Pointer, count and busy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            count <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            addr  <= start_addr;
            count <= start_count;
            busy  <= 1'b1;
        end else if (beat) begin
            addr  <= addr + ADDR_STEP;
            count <= count - CNT_STEP;
            if (last) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bmw_status.sv
// Status side of the engine: the sticky interrupt flag, the rejection
// flag and the captured register read data. Assumes its inputs are
// single-cycle qualified events from the top module.
module bmw_status #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              irq_en,
    input  logic              irq_clear,
    input  logic              accept,
    input  logic              accept_ok,
    input  logic              rd,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic              irq,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    import bmw_pkg::*;

    // Sticky interrupt flag; a set in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (done_evt && irq_en) begin
            irq <= 1'b1;
        end else if (irq_clear) begin
            irq <= 1'b0;
        end
    end

    // Rejection flag, updated by every idle load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (accept) begin
            err <= !accept_ok;
        end
    end

    // Read capture at the moment of the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (reg_sel_e'(sel) == SEL_COUNT) begin
                rdata <= DATA_W'(count);
            end else begin
                rdata <= DATA_W'(addr);
            end
        end
    end
endmodule

// File: rtl/bmw_dma_engine.sv
// Top of the bus-master write engine. It loads one descriptor, issues
// DWORD beats over a valid/ready port, pauses during register reads and
// flags the end of the transfer. Assumes the host side holds wr_ready
// meaningful only while wr_valid is high.
module bmw_dma_engine #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [CNT_W-1:0]  desc_count,
    input  logic              irq_en,
    input  logic              irq_clear,
    input  logic              reg_rd,
    input  logic              reg_sel,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic              irq,
    output logic              err
);
    import bmw_pkg::*;

    logic              desc_ok;
    logic              accept;
    logic              start;
    logic              beat;
    logic              last;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  remain;

    bmw_desc_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
        .addr  (desc_addr),
        .count (desc_count),
        .ok    (desc_ok)
    );

    // Load qualification, halt on read, and beat handshake
    always_comb begin
        accept   = desc_load && !busy;
        start    = accept && desc_ok;
        wr_valid = busy && !reg_rd;
        beat     = wr_valid && wr_ready;
        wr_addr  = {ptr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end

    bmw_progress #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_progress (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (desc_addr),
        .start_count (desc_count),
        .beat        (beat),
        .addr        (ptr),
        .count       (remain),
        .busy        (busy),
        .last        (last)
    );

    bmw_status #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (last),
        .irq_en    (irq_en),
        .irq_clear (irq_clear),
        .accept    (accept),
        .accept_ok (desc_ok),
        .rd        (reg_rd),
        .sel       (reg_sel),
        .addr      (ptr),
        .count     (remain),
        .irq       (irq),
        .err       (err),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/bmw_dma_checker.sv
// Port-level protocol checks for the bus-master write engine, bound to
// every instance of the top module. Observes ports only.
module bmw_dma_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_load,
    input logic [ADDR_W-1:0] desc_addr,
    input logic              irq_clear,
    input logic              reg_rd,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              irq,
    input logic              err
);
    p_lowbits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    p_step_on_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + ADDR_W'(4)));

    p_hold_no_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_valid && wr_ready)) |=> $stable(wr_addr));

    p_read_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !wr_valid);

    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    p_reject_misaligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_load && !busy && (desc_addr[1:0] != 2'b00)) |=> (err && !busy));
endmodule

bind bmw_dma_engine bmw_dma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .desc_load (desc_load),
    .desc_addr (desc_addr),
    .irq_clear (irq_clear),
    .reg_rd    (reg_rd),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .busy      (busy),
    .irq       (irq),
    .err       (err)
);

// File: tb/bmw_dma_engine_bench.sv
module bmw_dma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [31:0] desc_addr = '0;
    logic [21:0] desc_count = '0;
    logic        irq_en = 1'b0;
    logic        irq_clear = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_rdata;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic        busy;
    logic        irq;
    logic        err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    longint unsigned m_addr = 0;
    int              m_cnt = 0;
    bit              m_busy = 0;
    bit              m_irq = 0;
    bit              m_err = 0;
    longint unsigned m_rdata = 0;
    longint unsigned beat_log[$];
    int              beats_seen = 0;

    always #4 clk = ~clk;

    bmw_dma_engine u_bmw_dma_engine (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_addr(desc_addr),
        .desc_count(desc_count), .irq_en(irq_en), .irq_clear(irq_clear),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .busy(busy), .irq(irq), .err(err)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // reference model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_busy = 0; m_irq = 0; m_err = 0; m_rdata = 0;
        end else begin
            bit ok;
            bit fire;
            bit fin;
            fire = m_busy && !reg_rd && wr_ready;
            fin = fire && (m_cnt == 4);
            ok = (desc_addr % 4 == 0) && (desc_count % 4 == 0) && (desc_count != 0);
            if (reg_rd) m_rdata = reg_sel ? longint'(m_cnt) : m_addr;
            if (fin && irq_en) m_irq = 1;
            else if (irq_clear) m_irq = 0;
            if (desc_load && !m_busy) begin
                m_err = !ok;
                if (ok) begin
                    m_addr = desc_addr; m_cnt = desc_count; m_busy = 1;
                    beat_log.delete();
                end
            end else if (fire) begin
                beat_log.push_back(m_addr);
                beats_seen++;
                m_addr = (m_addr + 4) & 64'hFFFF_FFFF;
                m_cnt -= 4;
                if (m_cnt == 0) m_busy = 0;
            end
        end
    end

    // compare every cycle, mid low phase
    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            check("R1 busy", busy, m_busy);
            check("R1/R6 wr_valid", wr_valid, m_busy && !reg_rd);
            check("R3 wr_addr", wr_addr, m_addr);
            if (wr_valid) check("R2 low bits", wr_addr[1:0], 0);
            check("R5 irq", irq, m_irq);
            check("R8 err", err, m_err);
            check("R6 rdata", reg_rdata, m_rdata);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] a, input logic [21:0] c);
        @(negedge clk);
        desc_load = 1'b1; desc_addr = a; desc_count = c;
        @(negedge clk);
        desc_load = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy && cycles < 20000) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #160000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R10 reset state
        check("R10 busy", busy, 0);
        check("R10 wr_valid", wr_valid, 0);
        check("R10 irq", irq, 0);
        check("R10 err", err, 0);
        check("R10 rdata", reg_rdata, 0);
        rst_n = 1'b1;
        tick(1);
        reg_rd = 1'b1; reg_sel = 1'b1; tick(1); reg_rd = 1'b0;
        tick(1);
        check("R10 count zero", reg_rdata, 0);

        // plain transfer, always ready, interrupt enabled
        irq_en = 1'b1; wr_ready = 1'b1;
        load(32'h0000_1000, 22'd16);
        wait_idle(); tick(1);
        check("R7 beat count", beat_log.size(), 4);
        check("R4 pointer past end", wr_addr, 32'h0000_1010);
        check("R5 irq set", irq, 1);
        tick(3);
        check("R5 irq sticky", irq, 1);
        irq_clear = 1'b1; tick(1); irq_clear = 1'b0; tick(1);
        check("R5 irq cleared", irq, 0);

        // stalls and pauses, interrupt disabled, ignored load while busy
        irq_en = 1'b0;
        load(32'h0000_2000, 22'd40);
        for (int i = 0; i < 60 && busy; i++) begin
            wr_ready = (i % 3) != 1;
            reg_rd = (i % 5) == 2;
            reg_sel = (i % 2) == 0;
            if (i == 4) begin
                desc_load = 1'b1; desc_addr = 32'h0000_9000; desc_count = 22'd8;
            end else begin
                desc_load = 1'b0;
            end
            tick(1);
        end
        reg_rd = 1'b0; desc_load = 1'b0; wr_ready = 1'b1;
        wait_idle(); tick(1);
        check("R9 ignored load end pointer", wr_addr, 32'h0000_2028);
        check("R7 beat count", beat_log.size(), 10);
        for (int k = 0; k < beat_log.size(); k++)
            check("R7 contiguous", beat_log[k], 64'h2000 + 4 * k);
        check("R5 no irq when disabled", irq, 0);

        // read of count with reserved bits zero during a large count
        wr_ready = 1'b0;
        load(32'hFFFF_FFF0, 22'h20_0010);
        reg_rd = 1'b1; reg_sel = 1'b1; tick(1); reg_rd = 1'b0; tick(1);
        check("R6 count readback", reg_rdata, 32'h0020_0010);
        reg_rd = 1'b1; reg_sel = 1'b0; tick(1); reg_rd = 1'b0; tick(1);
        check("R6 pointer readback", reg_rdata, 32'hFFFF_FFF0);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);

        // rejections
        wr_ready = 1'b1;
        load(32'h0000_3002, 22'd8); tick(1);
        check("R8 misaligned addr err", err, 1);
        check("R8 misaligned no busy", busy, 0);
        load(32'h0000_3000, 22'd6); tick(1);
        check("R8 odd count err", err, 1);
        load(32'h0000_3000, 22'd0); tick(1);
        check("R8 zero count err", err, 1);
        check("R8 no beat", wr_valid, 0);
        load(32'h0000_3000, 22'd4); tick(1);
        check("R8 err cleared by accepted load", err, 0);
        wait_idle(); tick(2);
        check("R7 single beat", beat_log.size(), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule